// File: doc/BRIEF.md
# Ball Motion Controller

This block keeps the state of the ball in a two-paddle video game: its position (x, y) and its signed velocity (vx, vy). The state changes only on cycles where the game-tick enable is high. On each tick the block does exactly one of the following: serve the ball from the centre, move it freely, bounce it off the top or bottom wall, return it from a paddle with a new vertical angle, or declare a miss. The block runs from the same clock as the rest of the game logic.

The playfield spans 0..`x_max` horizontally and 0..`y_max` vertically, with y growing downward. The left paddle sits at x = 0 and the right paddle at x = `x_max`. Each paddle covers the rows `pad_y` .. `pad_y + PADDLE_H - 1`. The position outputs feed the display logic. The miss pulse tells the score logic that the ball got past a paddle. The serve request comes from the main game-mode logic, and the paddle rows come from the paddle control logic.

Top module: `ball_motion`

## Requirements
- R1: While reset is asserted, and after it is released, `ball_x`, `ball_y` and `miss` are 0. The ball stays idle and does not move until the first serve.
- R2: On a clock where `tick_en` is low, `ball_x` and `ball_y` keep their values.
- R3: A tick with `serve_req` high sets x = `x_max`>>1 and y = `y_max`>>1, and sets vy to 0. It sets vx to +SERVE_SPEED when `serve_dir` is 1 (rightward) and to -SERVE_SPEED when `serve_dir` is 0. A serve takes priority over every other kind of update, including an idle ball.
- R4: On a tick with no edge or wall event, x becomes x+vx and y becomes y+vy.
- R5: If y+vy < 0, then y becomes 0 and vy is negated. If y+vy > `y_max`, then y becomes `y_max` and vy is negated. In both cases x still becomes x+vx.
- R6: The ball reaches the left edge when vx < 0 and x+vx <= 0. It reaches the right edge when vx > 0 and x+vx >= `x_max`. The edge test is made before the wall test. If the current y lies within that side's paddle span, x is clamped to the edge, vx is negated and y is left unchanged.
- R7: On a paddle return, let off = y - `pad_y`. If off < PADDLE_H/3, vy decreases by 1. If off >= PADDLE_H - PADDLE_H/3, vy increases by 1. Otherwise vy is unchanged. The result is saturated to ±MAX_VY.
- R8: If the ball reaches an edge with y outside that paddle's span, x is clamped to the edge and `miss` is high for exactly one clock, in the cycle after that tick. The ball then holds its position on every tick until a serve.
- R9: While `x_max` and `y_max` are held constant, `ball_x` <= `x_max` and `ball_y` <= `y_max` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | One-cycle game-tick enable |
| serve_req | input | 1 | Serve on this tick |
| serve_dir | input | 1 | Serve direction, 1 = rightward |
| x_max | input | POS_W | Right edge column |
| y_max | input | POS_W | Bottom wall row |
| left_pad_y | input | POS_W | Top row of the left paddle |
| right_pad_y | input | POS_W | Top row of the right paddle |
| ball_x | output | POS_W | Ball column |
| ball_y | output | POS_W | Ball row |
| miss | output | 1 | One-cycle pulse: the ball passed a paddle |

## Verification
The assertions check the following on every cycle:
- positions stay frozen between ticks;
- a serve lands at the centre;
- vy stays inside the saturation limit;
- the miss pulse lasts a single cycle, with the ball clamped to an edge;
- the ball never leaves the playfield.

Several behaviours can only be shown by the bench's tick-by-tick scenarios against its own model of the rules:
- the ordering between an edge event and a wall event in the same tick;
- the ±1 angle change for each paddle third;
- the ball staying frozen after a miss;
- a serve overriding an ongoing rally.

// File: rtl/ball_pkg.sv
package ball_pkg;
  // Where on a paddle the ball struck
  typedef enum logic [1:0] {
    ZN_MID  = 2'd0,
    ZN_UP   = 2'd1,
    ZN_DOWN = 2'd2
  } zone_e;

  // Kind of update selected for one tick
  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_SERVE = 3'd1,
    ST_FREE  = 3'd2,
    ST_WALL  = 3'd3,
    ST_HIT   = 3'd4,
    ST_MISS  = 3'd5
  } step_e;
endpackage

// File: rtl/ball_rst_sync.sv
module ball_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ball_zone.sv
module ball_zone
  import ball_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int PADDLE_H = 24
) (
  input  logic [POS_W-1:0] ball_y,
  input  logic [POS_W-1:0] pad_y,
  output logic             hit,
  output zone_e            zone
);
  localparam int W     = POS_W + 1;
  localparam int THIRD = PADDLE_H / 3;
  localparam logic [W-1:0] SPAN_W = W'(PADDLE_H);
  localparam logic [W-1:0] UP_W   = W'(THIRD);
  localparam logic [W-1:0] LOW_W  = W'(PADDLE_H - THIRD);

  logic [W-1:0] off;

  always_comb begin
    // A negative offset wraps around and sets the top bit.
    off  = {1'b0, ball_y} - {1'b0, pad_y};
    hit  = !off[W-1] && (off < SPAN_W);
    if (off < UP_W)        zone = ZN_UP;    // R7 upper third
    else if (off >= LOW_W) zone = ZN_DOWN;  // R7 lower third
    else                   zone = ZN_MID;
  end
endmodule

// File: rtl/ball_step.sv
module ball_step
  import ball_pkg::*;
#(
  parameter int POS_W       = 10,
  parameter int VEL_W       = 4,
  parameter int MAX_VY      = 3,
  parameter int SERVE_SPEED = 2
) (
  input  logic                    run,
  input  logic                    serve_req,
  input  logic                    serve_dir,
  input  logic [POS_W-1:0]        x,
  input  logic [POS_W-1:0]        y,
  input  logic signed [VEL_W-1:0] vx,
  input  logic signed [VEL_W-1:0] vy,
  input  logic [POS_W-1:0]        x_max,
  input  logic [POS_W-1:0]        y_max,
  input  logic                    hit_l,
  input  logic                    hit_r,
  input  zone_e                   zone_l,
  input  zone_e                   zone_r,
  output logic [POS_W-1:0]        nx,
  output logic [POS_W-1:0]        ny,
  output logic signed [VEL_W-1:0] nvx,
  output logic signed [VEL_W-1:0] nvy,
  output logic                    nrun,
  output step_e                   kind
);
  localparam int WD = POS_W + 2;
  localparam logic signed [VEL_W-1:0] SPD_V = VEL_W'(SERVE_SPEED);
  localparam logic signed [VEL_W:0]   VMAX  = (VEL_W+1)'(MAX_VY);
  localparam logic signed [VEL_W:0]   ONE   = (VEL_W+1)'(1);

  function automatic logic signed [VEL_W-1:0] bend(input logic signed [VEL_W-1:0] v,
                                                  input zone_e z);
    logic signed [VEL_W:0] t;
    t = {v[VEL_W-1], v};
    if (z == ZN_UP)        t = t - ONE;
    else if (z == ZN_DOWN) t = t + ONE;
    if (t > VMAX)       t = VMAX;
    else if (t < -VMAX) t = -VMAX;
    return t[VEL_W-1:0];
  endfunction

  logic signed [WD-1:0] sx, sy, xm, ym;
  logic edge_l, edge_r, wall_t, wall_b;

  always_comb begin
    sx = $signed({2'b00, x}) + {{(WD-VEL_W){vx[VEL_W-1]}}, vx};
    sy = $signed({2'b00, y}) + {{(WD-VEL_W){vy[VEL_W-1]}}, vy};
    xm = $signed({2'b00, x_max});
    ym = $signed({2'b00, y_max});
    edge_l = vx[VEL_W-1] && (sx[WD-1] || (sx == '0));
    edge_r = !vx[VEL_W-1] && !sx[WD-1] && (sx >= xm);
    wall_t = sy[WD-1];
    wall_b = !sy[WD-1] && (sy > ym);

    nx = x; ny = y; nvx = vx; nvy = vy; nrun = run; kind = ST_HOLD;
    if (serve_req) begin                       // R3 highest priority
      nx   = x_max >> 1;
      ny   = y_max >> 1;
      nvx  = serve_dir ? SPD_V : -SPD_V;
      nvy  = '0;
      nrun = 1'b1;
      kind = ST_SERVE;
    end else if (run) begin
      if (edge_l || edge_r) begin              // R6 edge before wall
        nx = edge_l ? '0 : x_max;
        if (edge_l ? hit_l : hit_r) begin
          nvx  = -vx;
          nvy  = bend(vy, edge_l ? zone_l : zone_r);
          kind = ST_HIT;
        end else begin                         // R8
          nrun = 1'b0;
          kind = ST_MISS;
        end
      end else if (wall_t || wall_b) begin     // R5
        nx   = sx[POS_W-1:0];
        ny   = wall_t ? '0 : y_max;
        nvy  = -vy;
        kind = ST_WALL;
      end else begin                           // R4
        nx   = sx[POS_W-1:0];
        ny   = sy[POS_W-1:0];
        kind = ST_FREE;
      end
    end
  end
endmodule

// File: rtl/ball_motion.sv
module ball_motion
  import ball_pkg::*;
#(
  parameter int POS_W       = 10,
  parameter int VEL_W       = 4,
  parameter int PADDLE_H    = 24,
  parameter int MAX_VY      = 3,
  parameter int SERVE_SPEED = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             serve_req,
  input  logic             serve_dir,
  input  logic [POS_W-1:0] x_max,
  input  logic [POS_W-1:0] y_max,
  input  logic [POS_W-1:0] left_pad_y,
  input  logic [POS_W-1:0] right_pad_y,
  output logic [POS_W-1:0] ball_x,
  output logic [POS_W-1:0] ball_y,
  output logic             miss
);
  localparam int SIDES = 2;

  logic rst_sync_n;
  logic [POS_W-1:0] x_q, y_q, x_d, y_d;
  logic signed [VEL_W-1:0] vx_q, vy_q, vx_d, vy_d;
  logic run_q, run_d, miss_q;
  step_e kind;
  logic  hit_s  [SIDES];
  zone_e zone_s [SIDES];

  ball_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // index 0 = left paddle, 1 = right paddle
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    ball_zone #(.POS_W(POS_W), .PADDLE_H(PADDLE_H)) u_zone (
      .ball_y(y_q),
      .pad_y (s == 0 ? left_pad_y : right_pad_y),
      .hit   (hit_s[s]),
      .zone  (zone_s[s])
    );
  end

  ball_step #(
    .POS_W(POS_W), .VEL_W(VEL_W), .MAX_VY(MAX_VY), .SERVE_SPEED(SERVE_SPEED)
  ) u_step (
    .run(run_q), .serve_req(serve_req), .serve_dir(serve_dir),
    .x(x_q), .y(y_q), .vx(vx_q), .vy(vy_q),
    .x_max(x_max), .y_max(y_max),
    .hit_l(hit_s[0]), .hit_r(hit_s[1]),
    .zone_l(zone_s[0]), .zone_r(zone_s[1]),
    .nx(x_d), .ny(y_d), .nvx(vx_d), .nvy(vy_d), .nrun(run_d), .kind(kind)
  );

  // R1 reset state; R2 clock enable on tick only
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      x_q <= '0; y_q <= '0; vx_q <= '0; vy_q <= '0;
      run_q <= 1'b0; miss_q <= 1'b0;
    end else begin
      miss_q <= tick_en && (kind == ST_MISS);   // R8 single-cycle pulse
      if (tick_en) begin
        x_q <= x_d; y_q <= y_d; vx_q <= vx_d; vy_q <= vy_d; run_q <= run_d;
      end
    end
  end

  assign ball_x = x_q;
  assign ball_y = y_q;
  assign miss   = miss_q;
endmodule

// File: rtl/ball_motion_chk.sv
module ball_motion_chk #(
  parameter int POS_W  = 10,
  parameter int VEL_W  = 4,
  parameter int MAX_VY = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_en,
  input logic                    serve_req,
  input logic [POS_W-1:0]        x_max,
  input logic [POS_W-1:0]        y_max,
  input logic [POS_W-1:0]        ball_x,
  input logic [POS_W-1:0]        ball_y,
  input logic                    miss,
  input logic signed [VEL_W-1:0] vy_q
);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(ball_x) && $stable(ball_y));

  // R3
  serve_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && serve_req |=> (ball_x == ($past(x_max) >> 1)) && (ball_y == ($past(y_max) >> 1)));

  // R7
  vy_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vy_q <= MAX_VY) && (vy_q >= -MAX_VY));

  // R8
  miss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);

  // R8
  miss_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (ball_x == '0) || (ball_x == x_max));

  // R9
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ball_x <= x_max) && (ball_y <= y_max));
endmodule

bind ball_motion ball_motion_chk #(.POS_W(POS_W), .VEL_W(VEL_W), .MAX_VY(MAX_VY)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en), .serve_req(serve_req),
  .x_max(x_max), .y_max(y_max), .ball_x(ball_x), .ball_y(ball_y),
  .miss(miss), .vy_q(vy_q)
);

// File: tb/ball_motion_tb.sv
`timescale 1ns/1ps
module ball_motion_tb;
  localparam int POS_W = 10;
  localparam int PH    = 24;
  localparam int MAXV  = 3;
  localparam int SPD   = 2;
  localparam int XM    = 100;
  localparam int YM    = 60;

  typedef struct {
    int x;
    int y;
    bit miss;
    int tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, serve_req = 1'b0, serve_dir = 1'b0;
  logic [POS_W-1:0] x_max = POS_W'(XM), y_max = POS_W'(YM);
  logic [POS_W-1:0] lpad = '0, rpad = '0;
  logic [POS_W-1:0] ball_x, ball_y;
  logic miss;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  logic saw = 1'b0;
  int mx = 0, my = 0, mvx = 0, mvy = 0;
  bit mrun = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  ball_motion #(.POS_W(POS_W), .PADDLE_H(PH), .MAX_VY(MAXV), .SERVE_SPEED(SPD)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .serve_req(serve_req),
    .serve_dir(serve_dir), .x_max(x_max), .y_max(y_max),
    .left_pad_y(lpad), .right_pad_y(rpad),
    .ball_x(ball_x), .ball_y(ball_y), .miss(miss)
  );

  function automatic string tag_s(input int t);
    case (t)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Reference model built from the requirements
  task automatic model_step(input bit srv, input bit dir, input int lp, input int rp,
                            output exp_t e);
    int sx, sy, pad, edg, off;
    e.miss = 0;
    if (srv) begin                              // R3
      mx = XM / 2; my = YM / 2; mvx = dir ? SPD : -SPD; mvy = 0; mrun = 1; e.tag = 3;
    end else if (!mrun) begin                   // R8 frozen
      e.tag = 8;
    end else begin
      sx = mx + mvx; sy = my + mvy;
      if ((mvx < 0 && sx <= 0) || (mvx > 0 && sx >= XM)) begin
        pad = (mvx < 0) ? lp : rp;
        edg = (mvx < 0) ? 0 : XM;
        mx = edg;
        if (my >= pad && my <= pad + PH - 1) begin   // R6
          off = my - pad;
          mvx = -mvx;
          e.tag = 6;
          if (off < PH / 3) begin mvy = mvy - 1; e.tag = 7; end            // R7
          else if (off >= PH - PH / 3) begin mvy = mvy + 1; e.tag = 7; end
          if (mvy > MAXV) mvy = MAXV;
          if (mvy < -MAXV) mvy = -MAXV;
        end else begin                            // R8
          mrun = 0; e.miss = 1; e.tag = 8;
        end
      end else if (sy < 0) begin mx = sx; my = 0;  mvy = -mvy; e.tag = 5; end  // R5
      else if (sy > YM)    begin mx = sx; my = YM; mvy = -mvy; e.tag = 5; end
      else begin mx = sx; my = sy; e.tag = 4; end                              // R4
    end
    e.x = mx; e.y = my;
  endtask

  task automatic tick(input bit srv, input bit dir, input int lp, input int rp);
    exp_t e;
    if (lp < 0) lp = 0;
    if (rp < 0) rp = 0;
    if (lp > 1023) lp = 1023;
    if (rp > 1023) rp = 1023;
    @(negedge clk);
    serve_req = srv; serve_dir = dir;
    lpad = POS_W'(lp); rpad = POS_W'(rp);
    tick_en = 1'b1;
    model_step(srv, dir, lp, rp, e);
    q.push_back(e);
    @(negedge clk);
    tick_en = 1'b0; serve_req = 1'b0;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  always @(posedge clk) saw <= tick_en;

  // Monitor: compares each tick result one cycle after its edge
  always @(negedge clk) begin
    if (saw) begin
      if (q.size() == 0) begin
        chk(0, "R2", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(ball_x == POS_W'(e.x), tag_s(e.tag), int'(ball_x), e.x);
        chk(ball_y == POS_W'(e.y), tag_s(e.tag), int'(ball_y), e.y);
        chk(miss == e.miss, "R8", int'(miss), int'(e.miss));
        chk(ball_x <= x_max && ball_y <= y_max, "R9", int'(ball_y), YM);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ball_x == 0 && ball_y == 0 && miss == 0, "R1", int'(ball_x), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ball_x == 0 && ball_y == 0 && miss == 0, "R1", int'(ball_y), 0);

    tick(0, 0, 0, 0);                   // R1 idle: no motion before first serve
    tick(1, 1, 0, 20);                  // R3 serve right
    repeat (6) @(negedge clk);          // R2 no ticks
    chk(ball_x == POS_W'(XM/2), "R2", int'(ball_x), XM/2);
    chk(ball_y == POS_W'(YM/2), "R2", int'(ball_y), YM/2);

    for (int i = 0; i < 25; i++) tick(0, 0, 0, 20);        // R4 then R6 mid-third
    for (int i = 0; i < 80; i++) tick(0, 0, my - 3, my - 3);  // R7 upper third, R5 walls
    for (int i = 0; i < 80; i++) tick(0, 0, my - 20, my - 20); // R7 lower third
    for (int i = 0; i < 60; i++) tick(0, 0, my + 40, my + 40); // R8 miss then frozen
    @(negedge clk);
    chk(miss == 1'b0, "R8", int'(miss), 0);
    tick(1, 0, 0, 0);                   // R3 serve left
    for (int i = 0; i < 5; i++) tick(0, 0, my - 10, my - 10);
    tick(1, 1, 0, 0);                   // R3 serve overrides rally

    for (int i = 0; i < 400; i++) begin
      int off;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      off = int'(lf[7:0]) % 36 - 5;
      tick(lf[12:8] == 5'd0, lf[14], my - off, my - off);
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", q.size(), 0);
    finish_run();
  end
endmodule